// File: doc/BRIEF.md
# Linear frequency sweep generator

This block produces a 32-bit frequency tuning word every system clock for the phase accumulator of a direct digital synthesizer. The word changes linearly over time, so the synthesizer's output is a chirp. Software loads three values through a small write port: a starting tuning word, a signed step and a ramp-rate count. A level-sensitive start input then runs the sweep.

A divide-by-eight prescaler drives a reloadable countdown timer. Each time the timer expires, a frequency accumulator adds the step to the current word. The step is two's complement, so its sign sets the sweep direction. Additions wrap modulo 2^32. A ramp-rate of zero holds the word where it is.

Top module: `chirp_sweep_gen`

## Requirements
- R1: While rst_n is low, and afterwards until the first start, ftw_out is zero.
- R2: On the first clock edge at which start is sampled high after being low, ftw_out takes the starting word. The prescaler and the countdown restart at that same edge.
- R3: With an active ramp-rate R (1 or more), the first increment lands 8*R clock edges after the load edge. Each later increment lands 8*R edges after the previous one. ftw_out does not change between increments.
- R4: A positive step raises ftw_out by exactly the step at each increment.
- R5: The step is two's complement. A value with bit 31 set lowers ftw_out by its magnitude at each increment.
- R6: Additions wrap modulo 2^32 in both directions, with no saturation.
- R7: An active ramp-rate of 0 produces no increments. ftw_out keeps the starting word for as long as start stays high.
- R8: While start is low, ftw_out and the sweep timing are frozen. Raising start again reloads the sweep as in R2.
- R9: Writes go through wr_en, wr_addr and wr_data. Address 0 is the starting word, address 1 is the step, and address 2 is the ramp-rate, taken from wr_data[15:0]. Address 3 is ignored. A written step or ramp-rate takes effect only at the next load or timer reload. A written starting word takes effect only at the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 start word, 1 step, 2 ramp-rate |
| wr_data | input | 32 | Register write data |
| start | input | 1 | High runs the sweep; a rising level reloads it; low freezes it |
| ftw_out | output | 32 | Instantaneous frequency tuning word |

## Verification
The hardest case to reach is a register write that lands in the middle of a running sweep. Its effect must be deferred until the exact edge at which the countdown reloads. The stimulus changes the step and the ramp-rate while start stays high. The scoreboard's model then requires the old step and interval up to the next expiry, and the new ones after it. Wraparound through zero in both directions is reached by placing the starting word a few steps from the 32-bit boundary.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  localparam int FTW_W   = 32;
  localparam int RATE_W  = 16;
  localparam int ADDR_W  = 2;
  localparam int PRE_DIV = 8;

  typedef enum logic [ADDR_W-1:0] {
    SEL_START = 2'd0,
    SEL_STEP  = 2'd1,
    SEL_RATE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/chirp_regfile.sv
module chirp_regfile
  import chirp_pkg::*;
#(
  parameter int W_FTW  = FTW_W,
  parameter int W_RATE = RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W_FTW-1:0]  wr_data,
  output logic [W_FTW-1:0]  start_word,
  output logic [W_FTW-1:0]  step_word,
  output logic [W_RATE-1:0] rate_word
);
  logic [W_FTW-1:0]  start_d, step_d;
  logic [W_RATE-1:0] rate_d;
  logic              en_start, en_step, en_rate;

  // Address decode: one clock enable per register
  always_comb begin
    en_start = wr_en && (reg_sel_e'(wr_addr) == SEL_START);
    en_step  = wr_en && (reg_sel_e'(wr_addr) == SEL_STEP);
    en_rate  = wr_en && (reg_sel_e'(wr_addr) == SEL_RATE);
  end

  always_comb begin
    start_d = start_word;
    step_d  = step_word;
    rate_d  = rate_word;
    if (en_start) start_d = wr_data;
    if (en_step)  step_d  = wr_data;
    if (en_rate)  rate_d  = wr_data[W_RATE-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_word <= '0;
      step_word  <= '0;
      rate_word  <= '0;
    end else begin
      start_word <= start_d;
      step_word  <= step_d;
      rate_word  <= rate_d;
    end
  end
endmodule

// File: rtl/chirp_prescaler.sv
module chirp_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (run)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && !clear && (cnt_q == LAST);
endmodule

// File: rtl/chirp_rate_timer.sv
module chirp_rate_timer #(
  parameter int W_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic [W_RATE-1:0] reload_val,
  output logic              expire,
  output logic [W_RATE-1:0] remaining
);
  localparam logic [W_RATE-1:0] ONE = W_RATE'(1);

  logic [W_RATE-1:0] cnt_q, cnt_d;

  assign expire = tick && !load && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (load || expire)
      cnt_d = reload_val;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign remaining = cnt_q;
endmodule

// File: rtl/chirp_freq_acc.sv
module chirp_freq_acc #(
  parameter int W_FTW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [W_FTW-1:0] start_word,
  input  logic [W_FTW-1:0] step_word,
  output logic [W_FTW-1:0] acc,
  output logic [W_FTW-1:0] step_act
);
  logic [W_FTW-1:0] acc_d, step_d;

  always_comb begin
    acc_d  = acc;
    step_d = step_act;
    if (load) begin
      acc_d  = start_word;
      step_d = step_word;
    end else if (step) begin
      acc_d  = acc + step_act;   // modulo 2^W_FTW, sign carried by the step
      step_d = step_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      step_act <= '0;
    end else begin
      acc      <= acc_d;
      step_act <= step_d;
    end
  end
endmodule

// File: rtl/chirp_sweep_gen.sv
module chirp_sweep_gen
  import chirp_pkg::*;
#(
  parameter int W_FTW  = FTW_W,
  parameter int W_RATE = RATE_W,
  parameter int DIV    = PRE_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W_FTW-1:0]  wr_data,
  input  logic              start,
  output logic [W_FTW-1:0]  ftw_out
);
  logic              start_q;
  logic              load, run;
  logic              presc_tick, expire;
  logic [W_FTW-1:0]  start_word, step_word, step_act;
  logic [W_RATE-1:0] rate_word, remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start;
  end

  assign load = start && !start_q;
  assign run  = start && start_q;

  chirp_regfile #(.W_FTW(W_FTW), .W_RATE(W_RATE)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start_word(start_word), .step_word(step_word),
    .rate_word(rate_word)
  );

  chirp_prescaler #(.DIV(DIV)) presc_i (
    .clk(clk), .rst_n(rst_n), .clear(load), .run(run), .tick(presc_tick)
  );

  chirp_rate_timer #(.W_RATE(W_RATE)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(load), .tick(presc_tick),
    .reload_val(rate_word), .expire(expire), .remaining(remaining)
  );

  chirp_freq_acc #(.W_FTW(W_FTW)) acc_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(expire),
    .start_word(start_word), .step_word(step_word),
    .acc(ftw_out), .step_act(step_act)
  );
endmodule

// File: rtl/chirp_sweep_chk.sv
module chirp_sweep_chk #(
  parameter int W_FTW  = 32,
  parameter int W_RATE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [W_FTW-1:0]  ftw_out,
  input logic [W_FTW-1:0]  start_word,
  input logic [W_FTW-1:0]  step_act,
  input logic              presc_tick,
  input logic              expire,
  input logic [W_RATE-1:0] remaining
);
  logic start_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_prev <= 1'b0;
    else        start_prev <= start;
  end

  // R2
  load_start_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_prev) |=> (ftw_out == $past(start_word)));

  // R3
  no_step_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_prev && !presc_tick) |=> $stable(ftw_out));

  // R3
  expire_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> presc_tick);

  // R4
  step_adds_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_prev && expire) |=> (ftw_out == $past(ftw_out) + $past(step_act)));

  // R7
  zero_rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_prev && remaining == '0) |=> $stable(ftw_out));

  // R8
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ftw_out));
endmodule

bind chirp_sweep_gen chirp_sweep_chk #(.W_FTW(W_FTW), .W_RATE(W_RATE)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ftw_out(ftw_out),
  .start_word(start_word), .step_act(step_act), .presc_tick(presc_tick),
  .expire(expire), .remaining(remaining)
);

// File: tb/chirp_sweep_gen_tb_top.sv
module chirp_sweep_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] ftw_out;

  always #5 clk = ~clk;

  chirp_sweep_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .ftw_out(ftw_out)
  );

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  logic [31:0] m_start = 0, m_step = 0, m_acc = 0, l_step = 0;
  int          m_rate = 0, l_rate = 0, m_n = 0;
  logic        m_prev = 1'b0;

  // Driver: set inputs, predict ftw_out after the next edge, push it
  task automatic drive(input logic st, input logic we, input logic [1:0] a,
                       input logic [31:0] d, input string req);
    item_t it;
    @(negedge clk);
    start = st; wr_en = we; wr_addr = a; wr_data = d;
    if (st && !m_prev) begin
      m_acc = m_start; m_n = 0; l_rate = m_rate; l_step = m_step;
    end else if (st) begin
      m_n++;
      if (l_rate != 0 && m_n == 8 * l_rate) begin
        m_acc  = m_acc + l_step;
        m_n    = 0;
        l_rate = m_rate;
        l_step = m_step;
      end
    end
    m_prev = st;
    if (we) begin
      case (a)
        2'd0: m_start = d;
        2'd1: m_step  = d;
        2'd2: m_rate  = int'(d[15:0]);
        default: ;
      endcase
    end
    it.exp = m_acc; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic run(input int n, input logic st, input string req);
    for (int i = 0; i < n; i++) drive(st, 1'b0, 2'd0, 32'd0, req);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
    drive(start, 1'b1, a, d, req);
  endtask

  // Monitor: compare one expected item after each edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (rst_n && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_checks++;
      if (ftw_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: ftw_out=%h expected=%h at %0t", it.req, ftw_out, it.exp, $time);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;   // R1 during reset
    if (ftw_out !== 32'd0) begin
      n_fail++; $display("FAIL R1: ftw_out=%h expected=%h", ftw_out, 32'd0);
    end
    rst_n = 1'b1;

    // R1 idle after reset, R9 register writes incl. ignored address 3
    wr(2'd0, 32'h1000_0000, "R1");
    wr(2'd1, 32'h0000_0100, "R9");
    wr(2'd2, 32'h0001_0001, "R9");
    wr(2'd3, 32'hDEAD_BEEF, "R9");
    run(1, 1'b1, "R2");
    run(40, 1'b1, "R4");
    run(10, 1'b0, "R8");

    // Down sweep, slower rate
    wr(2'd1, 32'hFFFF_FFC0, "R5");
    wr(2'd2, 32'd3, "R3");
    run(1, 1'b1, "R2");
    run(100, 1'b1, "R5");
    run(2, 1'b0, "R8");

    // Upward wrap through zero
    wr(2'd0, 32'hFFFF_FF00, "R6");
    wr(2'd1, 32'h0000_0080, "R6");
    wr(2'd2, 32'd2, "R6");
    run(1, 1'b1, "R2");
    run(60, 1'b1, "R6");
    run(1, 1'b0, "R8");

    // Downward wrap through zero
    wr(2'd0, 32'h0000_0040, "R6");
    wr(2'd1, 32'hFFFF_FFD0, "R6");
    wr(2'd2, 32'd1, "R6");
    run(1, 1'b1, "R2");
    run(40, 1'b1, "R6");
    run(1, 1'b0, "R8");

    // Zero ramp-rate holds
    wr(2'd2, 32'd0, "R7");
    run(1, 1'b1, "R2");
    run(40, 1'b1, "R7");
    run(1, 1'b0, "R8");

    // Writes during a running sweep are deferred to the next reload or start
    wr(2'd2, 32'd2, "R9");
    wr(2'd1, 32'h0000_0010, "R9");
    wr(2'd0, 32'h0000_0500, "R9");
    run(1, 1'b1, "R2");
    run(5, 1'b1, "R9");
    wr(2'd2, 32'd1, "R9");
    wr(2'd1, 32'h0000_1000, "R9");
    wr(2'd0, 32'h0000_9999, "R9");
    run(60, 1'b1, "R9");
    run(1, 1'b0, "R8");
    run(1, 1'b1, "R9");
    run(20, 1'b1, "R3");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule